// File: doc/BRIEF.md
# Serial Input-Status Reader Interface

This block is the serial read-out port of an eight-channel status receiver. It keeps a live copy of the eight filtered channel levels, two alarm flags and four overlapping parity bits. On the falling edge of chip select it freezes that copy into a shift register. It then clocks the word out, most significant bit first, in SPI mode 0. A strap input selects a 16-bit word (data plus control byte) or an 8-bit word (data only).

The serial pins are sampled by a fast system clock through synchronizer chains, and every edge is detected in that clock domain. The block drives a true and a complemented serial output under a common output enable. Data that arrives on the serial input is shifted in behind the local word, so several readers can be chained. A power-loss input pulls the serial output low for as long as it is asserted.

Top module: `status_spi_slave`

## Requirements
- R1: In 16-bit mode the word is, from bit 15 down: channel 7..0 in bits 15..8, bit 7 = NOT undervoltage alarm, bit 6 = NOT overtemperature alarm, bits 5..2 = parity bits, bit 1 = 0, bit 0 = 1. The word is sent most significant bit first.
- R2: A parity bit is 1 when its group holds an even count of ones. The groups are: bit 5 covers channels 0..7, bit 4 covers channels 4..7, bit 3 covers channels 0..3, bit 2 covers channels 2..5.
- R3: The word is captured when chip select falls. Channel and alarm changes while chip select stays low do not alter the word being sent.
- R4: Bit 15 is on the serial output before any clock edge. Each later bit appears after a falling serial-clock edge.
- R5: A falling serial-clock edge shifts only if a rising edge has occurred since chip select fell. When the serial clock is high at select, the first fall is ignored.
- R6: With the frame-size strap high, the word is 8 bits long and holds only bits 15..8 of R1.
- R7: While chip select is high, the output enable is low. While the outputs are enabled, the complemented output is the inverse of the true output.
- R8: Serial input is captured on each rising serial-clock edge. It reappears on the serial output exactly one frame length later (16 or 8 bits, by the strap).
- R9: While power-loss is high, the true output is driven low on every bit, including bit 0.
- R10: After reset the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_lvl | input | 8 | Filtered channel levels, bit 7 = highest channel |
| uv_alarm | input | 1 | Undervoltage alarm, active high |
| ot_alarm | input | 1 | Overtemperature alarm, active high |
| pwr_lost | input | 1 | Power-loss flag, forces serial output low |
| short_frame | input | 1 | Frame-size strap: 0 = 16 bits, 1 = 8 bits |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in (chain input) |
| sdo | output | 1 | Serial data out |
| sdo_n | output | 1 | Complemented serial data out |
| sdo_oe | output | 1 | Output enable for both serial outputs |

## Verification
The bench builds the block with its default parameters: eight channels and two-stage synchronizers. This makes the real 16-bit and 8-bit word layouts, the overlapping parity groups and the full chain delay observable at the pins. The serial clock runs at one sixteenth of the system clock, which leaves enough margin for the synchronizer and output-register latency within each half period. Under that setting the bench exercises the early-high serial clock case, input changes during a transfer, and power loss.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int CHANS   = 8;
  localparam int FRAME_W = 2 * CHANS;
  typedef logic [FRAME_W-1:0] frame_t;

  // even count of ones -> 1
  function automatic logic even_par(input logic [CHANS-1:0] v, input logic [CHANS-1:0] msk);
    return ~^(v & msk);
  endfunction

  function automatic frame_t pack_word(input logic [CHANS-1:0] lvl, input logic uv, input logic ot);
    frame_t w;
    w[FRAME_W-1:CHANS] = lvl;
    w[7] = ~uv;
    w[6] = ~ot;
    w[5] = even_par(lvl, 8'hFF);
    w[4] = even_par(lvl, 8'hF0);
    w[3] = even_par(lvl, 8'h0F);
    w[2] = even_par(lvl, 8'h3C);
    w[1] = 1'b0;
    w[0] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sss_word_build.sv
module sss_word_build
  import sss_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [CHANS-1:0] lvl,
  input  logic             uv,
  input  logic             ot,
  output frame_t           snap
);
  localparam frame_t RST_WORD = pack_word('0, 1'b0, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) snap <= RST_WORD;
    else if (!hold) snap <= pack_word(lvl, uv, ot);
  end

  a_r2_full_group_even: assert property (@(posedge clk) disable iff (rst)
    snap[5] == ~^snap[FRAME_W-1:CHANS]);
  a_r1_trailer_fixed: assert property (@(posedge clk) disable iff (rst)
    snap[1:0] == 2'b01);
endmodule

// File: rtl/sss_shifter.sv
module sss_shifter
  import sss_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cs_s,
  input  logic   sck_s,
  input  logic   sdi_s,
  input  logic   short_frame,
  input  frame_t snap,
  output logic   bit_out
);
  logic   cs_d, sck_d, armed, sdi_cap;
  frame_t shreg, shnext;
  logic   cs_fall, sck_rise, sck_fall;

  assign cs_fall  = cs_d & ~cs_s;
  assign sck_rise = ~sck_d & sck_s;
  assign sck_fall = sck_d & ~sck_s;

  always_comb begin
    shnext = {shreg[FRAME_W-2:0], sdi_cap};
    if (short_frame) shnext[CHANS] = sdi_cap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d    <= 1'b1;
      sck_d   <= 1'b0;
      armed   <= 1'b0;
      sdi_cap <= 1'b0;
      shreg   <= '0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
      if (cs_fall) begin
        shreg <= snap;
        armed <= 1'b0;
      end else if (!cs_s) begin
        if (sck_rise) begin
          armed   <= 1'b1;
          sdi_cap <= sdi_s;
        end
        if (sck_fall && armed) shreg <= shnext;
      end
    end
  end

  assign bit_out = shreg[FRAME_W-1];

  a_r3_load_on_select: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> shreg == $past(snap));
  a_r5_unarmed_fall_holds: assert property (@(posedge clk) disable iff (rst)
    (sck_fall && !armed && !cs_s && !cs_fall) |=> $stable(shreg));
endmodule

// File: rtl/status_spi_slave.sv
module status_spi_slave
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CHANS-1:0] chan_lvl,
  input  logic             uv_alarm,
  input  logic             ot_alarm,
  input  logic             pwr_lost,
  input  logic             short_frame,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_n,
  output logic             sdo_oe
);
  logic [2:0] pins_s;
  logic       cs_s, sck_s, sdi_s, bit_out, drv_bit;
  frame_t     snap;

  sss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sdi}), .q(pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  sss_word_build u_build (
    .clk(clk), .rst(rst), .hold(~cs_s), .lvl(chan_lvl),
    .uv(uv_alarm), .ot(ot_alarm), .snap(snap)
  );

  sss_shifter u_shift (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .short_frame(short_frame), .snap(snap), .bit_out(bit_out)
  );

  assign drv_bit = bit_out & ~pwr_lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_n  <= 1'b1;
      sdo_oe <= 1'b0;
    end else begin
      sdo    <= drv_bit;
      sdo_n  <= ~drv_bit;
      sdo_oe <= ~cs_s;
    end
  end

  a_r7_hiz_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);
  a_r7_outputs_complement: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (sdo_n != sdo));
  a_r9_power_loss_low: assert property (@(posedge clk) disable iff (rst)
    pwr_lost |=> !sdo);
endmodule

// File: tb/status_spi_slave_tb_top.sv
module status_spi_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] chan_lvl = '0;
  logic uv_alarm = 0, ot_alarm = 0, pwr_lost = 0, short_frame = 0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_n, sdo_oe;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  status_spi_slave dut_i (
    .clk(clk), .rst(rst), .chan_lvl(chan_lvl), .uv_alarm(uv_alarm),
    .ot_alarm(ot_alarm), .pwr_lost(pwr_lost), .short_frame(short_frame),
    .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_n(sdo_n), .sdo_oe(sdo_oe)
  );

  // {levels, uv, ot, short}
  localparam logic [10:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b0},
    {8'h1C, 1'b1, 1'b1, 1'b0},
    {8'h81, 1'b0, 1'b0, 1'b1},
    {8'h3E, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic grp_even(input logic [7:0] v, input int lo, input int hi);
    int c = 0;
    for (int k = lo; k <= hi; k++) c += v[k];
    return (c % 2) == 0;
  endfunction

  function automatic logic [15:0] exp_word(input logic [7:0] v, input logic uv, input logic ot);
    return {v, ~uv, ~ot, grp_even(v,0,7), grp_even(v,4,7), grp_even(v,0,3), grp_even(v,2,5), 2'b01};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nb, input logic [31:0] tx, input bit pre_high,
                      input bit do_mid, input logic [7:0] mid_val,
                      output logic [31:0] rx, output bit comp_ok, output logic first_after_ign);
    rx = '0; comp_ok = 1; first_after_ign = 1'bx;
    if (pre_high) begin sck = 1; tick(8); end
    cs_n = 0; tick(8);
    if (pre_high) begin sck = 0; tick(8); first_after_ign = sdo; end
    for (int i = 0; i < nb; i++) begin
      sdi = tx[nb-1-i];
      rx[nb-1-i] = sdo;
      if (!sdo_oe || (sdo_n !== ~sdo)) comp_ok = 0;
      if (do_mid && i == 3) begin chan_lvl = mid_val; uv_alarm = ~uv_alarm; end
      sck = 1; tick(8);
      sck = 0; tick(8);
    end
    cs_n = 1; sdi = 0; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rx;
    bit ok;
    logic fa;
    tick(4);
    check("R10 reset oe", sdo_oe, 0);
    rst = 0;
    tick(6);
    check("R7 idle oe low", sdo_oe, 0);

    // vector table walk: R1 R2 R4 R6
    foreach (VEC[v]) begin
      logic [15:0] ew;
      {chan_lvl, uv_alarm, ot_alarm, short_frame} = VEC[v];
      ew = exp_word(VEC[v][10:3], VEC[v][2], VEC[v][1]);
      tick(8);
      if (!VEC[v][0]) begin
        xfer(16, 32'h0, 0, 0, 8'h0, rx, ok, fa);
        check("R1 R2 R4 16-bit word", rx[15:0], ew);
      end else begin
        xfer(8, 32'h0, 0, 0, 8'h0, rx, ok, fa);
        check("R6 8-bit word", rx[7:0], ew[15:8]);
      end
      check("R7 complement while driven", ok, 1);
      check("R7 oe low after deselect", sdo_oe, 0);
    end

    // R3: changes during transfer ignored
    short_frame = 0; chan_lvl = 8'h5A; uv_alarm = 0; ot_alarm = 0; tick(8);
    xfer(16, 32'h0, 0, 1, 8'hC3, rx, ok, fa);
    check("R3 frozen word", rx[15:0], exp_word(8'h5A, 0, 0));
    tick(8);
    xfer(16, 32'h0, 0, 0, 8'h0, rx, ok, fa);
    check("R3 next word sees new state", rx[15:0], exp_word(8'hC3, 1, 0));

    // R5: SCK high when select falls
    chan_lvl = 8'h96; uv_alarm = 0; ot_alarm = 1; tick(8);
    xfer(16, 32'h0, 1, 0, 8'h0, rx, ok, fa);
    check("R5 first fall ignored, bit15 held", fa, 1'b1);
    check("R5 word intact", rx[15:0], exp_word(8'h96, 0, 1));

    // R8: chaining, 16-bit
    chan_lvl = 8'h0F; ot_alarm = 0; tick(8);
    xfer(32, 32'hBEEF_0000, 0, 0, 8'h0, rx, ok, fa);
    check("R8 local word first", rx[31:16], exp_word(8'h0F, 0, 0));
    check("R8 chain delay 16", rx[15:0], 16'hBEEF);
    // R8: chaining, 8-bit
    short_frame = 1; tick(8);
    xfer(16, 32'h0000_6D00, 0, 0, 8'h0, rx, ok, fa);
    check("R8 short local byte", rx[15:8], 8'h0F);
    check("R8 chain delay 8", rx[7:0], 8'h6D);

    // R9: power loss
    short_frame = 0; chan_lvl = 8'hFF; pwr_lost = 1; tick(8);
    xfer(16, 32'h0, 0, 0, 8'h0, rx, ok, fa);
    check("R9 all zero incl bit0", rx[15:0], 16'h0000);
    check("R9 complement still driven", ok, 1);
    pwr_lost = 0; tick(8);
    xfer(16, 32'h0, 0, 0, 8'h0, rx, ok, fa);
    check("R9 recovery", rx[15:0], exp_word(8'hFF, 0, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule